// File: doc/BRIEF.md
# Configuration-Guarded Interrupt Controller

This block sits beside the control registers of a four-channel-in, four-channel-out audio converter. It holds the power-down bits of every converter channel and the serial-port format and speed-mode fields. It flags misuse of those settings with sticky status bits. A change to the port format or the speed mode is only legal while the whole device is powered down. If either value changes while any channel is still powered up, a serial-port error is recorded.

An external monitor pulses a strobe when the master-clock-to-sample-rate ratio changes. Outside power-down, that strobe records both a clocking error and a serial-port error. A test-mode entry strobe and four ADC overflow inputs each record their own status bit, whatever the power state.

Each status bit has a mask bit. The unmasked bits are combined onto one registered, active-low interrupt line. Software reads the status register to learn the cause, and that read clears it.

Top module: `cfg_guard_irq`

## Requirements
- R1: After reset the power register reads 0xFF (every channel powered down), the port configuration and the mask read 0x00, the status register reads 0x00 and `irq_n` is 1.
- R2: The device counts as powered down only when all eight power-down bits are 1. While it is powered down, a configuration change or a ratio strobe sets no status bit.
- R3: A write to the configuration register that changes the format field (bits 1:0) while the device is not powered down sets status bit 6 (serial-port error).
- R4: A write to the configuration register that changes the speed-mode field (bits 3:2) while the device is not powered down sets status bit 6.
- R5: A configuration write whose format and speed fields equal the current values sets no error, even when the device is not powered down.
- R6: A `ratio_chg` pulse while the device is not powered down sets both status bit 5 (clocking error) and status bit 6.
- R7: A `test_mode_enter` pulse sets status bit 7 in any power state.
- R8: A pulse on `adc_ovfl[n]` sets status bit n, for n = 0 to 3.
- R9: The mask register uses the same bit positions as the status register. One cycle after the status or mask register settles, `irq_n` is 0 exactly when some status bit is 1 and its mask bit is 0. A mask bit of 1 keeps its event off the line.
- R10: A read of the status register returns its value and clears it. An event that arrives in the same cycle as the read is kept in the status register.
- R11: Register map on the 2-bit address: 0 is power (bits 3:0 are the ADC channel power-down bits and bits 7:4 the DAC bits), 1 is configuration (bits 7:4 read 0), 2 is the mask, 3 is status. Bit 4 of the mask and of the status register always reads 0. Read data appears on `reg_rdata` one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| ratio_chg | input | 1 | Clock-ratio change strobe from the external monitor |
| test_mode_enter | input | 1 | Unintended test-mode entry strobe |
| adc_ovfl | input | 4 | Per-channel ADC overflow strobes |
| adc_pwr_dn | output | 4 | ADC channel power-down bits |
| dac_pwr_dn | output | 4 | DAC channel power-down bits |
| port_fmt | output | 2 | Serial-port format field |
| port_speed | output | 2 | Speed-mode field |
| irq_n | output | 1 | Interrupt line, active low, registered |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never high in the same cycle. They also assume the event strobes are synchronous to `clk`, and that nothing but a read clears a status bit. The stimulus drives a single strobe per task and lets each task finish before the next starts. The one exception is the test of an event arriving with a status read, which deliberately overlaps a read with an overflow pulse. Power-state cases cover the device fully powered down, one ADC bit cleared, and one DAC bit cleared. This way the "not powered down" conditions of the format, speed and ratio rules are reached from both converter groups.

// File: rtl/cgi_pkg.sv
// Package cgi_pkg: shared sizes, register addresses and status bit positions
// for the configuration-guarded interrupt controller.
package cgi_pkg;
    localparam int DW    = 8;
    localparam int AW    = 2;
    localparam int N_ADC = 4;
    localparam int N_DAC = 4;
    localparam int PW    = N_ADC + N_DAC;

    localparam logic [AW-1:0] A_PWR  = 2'd0;
    localparam logic [AW-1:0] A_CFG  = 2'd1;
    localparam logic [AW-1:0] A_MASK = 2'd2;
    localparam logic [AW-1:0] A_STAT = 2'd3;

    localparam int B_TM  = 7;
    localparam int B_SP  = 6;
    localparam int B_CLK = 5;
    localparam int B_RSV = 4;

    typedef struct packed {
        logic [1:0] speed;
        logic [1:0] fmt;
    } port_cfg_t;
endpackage

// File: rtl/cgi_regs.sv
// Module cgi_regs: the power, configuration and mask registers and the
// registered read-back multiplexer.
// Assumes that a write and a read never share a cycle, and that the status
// value arrives from cgi_status.
module cgi_regs
    import cgi_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic [DW-1:0]   status_i,
    output logic [N_ADC-1:0] pd_adc,
    output logic [N_DAC-1:0] pd_dac,
    output port_cfg_t       cfg,
    output logic [DW-1:0]   mask,
    output logic [DW-1:0]   rdata
);
    localparam logic [DW-1:0] MASK_KEEP = ~(DW'(1) << B_RSV);

    logic [PW-1:0] pwr_q;
    port_cfg_t     cfg_q;
    logic [DW-1:0] mask_q;
    logic [DW-1:0] rdata_q;
    logic [DW-1:0] rd_mux;

    // Hold the software-writable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q  <= '1;
            cfg_q  <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            case (addr)
                A_PWR:   pwr_q  <= wdata[PW-1:0];
                A_CFG:   cfg_q  <= port_cfg_t'(wdata[3:0]);
                A_MASK:  mask_q <= wdata & MASK_KEEP;
                default: ;
            endcase
        end
    end

    // Select the read-back source for the addressed register.
    always_comb begin
        case (addr)
            A_PWR:   rd_mux = DW'(pwr_q);
            A_CFG:   rd_mux = DW'(cfg_q);
            A_MASK:  rd_mux = mask_q;
            default: rd_mux = status_i;
        endcase
    end

    // Register the read data on every read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_mux;
    end

    assign pd_adc = pwr_q[N_ADC-1:0];
    assign pd_dac = pwr_q[PW-1:N_ADC];
    assign cfg    = cfg_q;
    assign mask   = mask_q;
    assign rdata  = rdata_q;

    AST_MASK_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mask[B_RSV] == 1'b0); // R11
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R11
endmodule

// File: rtl/cgi_events.sv
// Module cgi_events: turns writes, strobes and the power state into a
// one-cycle event vector laid out like the status register.
// Assumes the strobes are synchronous one-cycle pulses. The event logic is
// purely combinational.
module cgi_events
    import cgi_pkg::*;
(
    input  logic             cfg_wr,
    input  port_cfg_t        cfg_new,
    input  port_cfg_t        cfg_cur,
    input  logic [N_ADC-1:0] pd_adc,
    input  logic [N_DAC-1:0] pd_dac,
    input  logic             ratio_stb,
    input  logic             tm_stb,
    input  logic [N_ADC-1:0] ovfl,
    output logic             all_pd,
    output logic [DW-1:0]    evt
);
    logic fmt_diff;
    logic spd_diff;

    assign all_pd   = (&pd_adc) & (&pd_dac);
    assign fmt_diff = cfg_new.fmt   != cfg_cur.fmt;
    assign spd_diff = cfg_new.speed != cfg_cur.speed;

    // Build the event vector in status-register bit order.
    always_comb begin
        evt          = '0;
        evt[B_TM]    = tm_stb;
        evt[B_CLK]   = ratio_stb & ~all_pd;
        evt[B_SP]    = ~all_pd & (ratio_stb | (cfg_wr & (fmt_diff | spd_diff)));
        evt[N_ADC-1:0] = ovfl;
    end
endmodule

// File: rtl/cgi_status.sv
// Module cgi_status: sticky status bits with clear-on-read, and the
// registered active-low interrupt line.
// Assumes that a clear request means "status was read this cycle". An event
// in the same cycle as the clear wins over the clear.
module cgi_status
    import cgi_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] evt,
    input  logic          clr,
    input  logic [DW-1:0] mask,
    output logic [DW-1:0] status,
    output logic          irq_n
);
    logic [DW-1:0] status_q;
    logic          irq_n_q;

    // One sticky flop per status bit.
    for (genvar i = 0; i < DW; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) status_q[i] <= 1'b0;
            else        status_q[i] <= (status_q[i] & ~clr) | evt[i];
        end
    end

    // Register the masked NOR so that the line never glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_n_q <= 1'b1;
        else        irq_n_q <= ~|(status_q & ~mask);
    end

    assign status = status_q;
    assign irq_n  = irq_n_q;

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == !$past(|(status & ~mask))); // R9
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && evt == '0) |=> status == '0); // R10
    AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((status & $past(evt)) == $past(evt))); // R10
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((status & $past(status)) == $past(status))); // R10
endmodule

// File: rtl/cfg_guard_irq.sv
// Module cfg_guard_irq: top level of the configuration-guarded interrupt
// controller. It ties the register file, the event detector and the status
// block together.
// Assumes that reg_wr and reg_rd are never high together and that all
// strobes are synchronous to clk.
module cfg_guard_irq
    import cgi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic             ratio_chg,
    input  logic             test_mode_enter,
    input  logic [N_ADC-1:0] adc_ovfl,
    output logic [N_ADC-1:0] adc_pwr_dn,
    output logic [N_DAC-1:0] dac_pwr_dn,
    output logic [1:0]       port_fmt,
    output logic [1:0]       port_speed,
    output logic             irq_n
);
    port_cfg_t     cfg;
    logic [DW-1:0] mask;
    logic [DW-1:0] status;
    logic [DW-1:0] evt;
    logic          all_pd;
    logic          cfg_wr;
    logic          stat_rd;
    port_cfg_t     cfg_new;

    assign cfg_wr  = reg_wr & (reg_addr == A_CFG);
    assign stat_rd = reg_rd & (reg_addr == A_STAT);
    assign cfg_new = port_cfg_t'(reg_wdata[3:0]);

    cgi_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .rd_en    (reg_rd),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .status_i (status),
        .pd_adc   (adc_pwr_dn),
        .pd_dac   (dac_pwr_dn),
        .cfg      (cfg),
        .mask     (mask),
        .rdata    (reg_rdata)
    );

    cgi_events u_events (
        .cfg_wr    (cfg_wr),
        .cfg_new   (cfg_new),
        .cfg_cur   (cfg),
        .pd_adc    (adc_pwr_dn),
        .pd_dac    (dac_pwr_dn),
        .ratio_stb (ratio_chg),
        .tm_stb    (test_mode_enter),
        .ovfl      (adc_ovfl),
        .all_pd    (all_pd),
        .evt       (evt)
    );

    cgi_status u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .clr    (stat_rd),
        .mask   (mask),
        .status (status),
        .irq_n  (irq_n)
    );

    assign port_fmt   = cfg.fmt;
    assign port_speed = cfg.speed;

    AST_FMT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CFG && reg_wdata[1:0] != port_fmt && !all_pd)
        |=> status[B_SP]); // R3
    AST_SPEED_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CFG && reg_wdata[3:2] != port_speed && !all_pd)
        |=> status[B_SP]); // R4
    AST_QUIET_POWERED_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(status[B_SP]) || $rose(status[B_CLK])) |-> !$past(&{adc_pwr_dn, dac_pwr_dn})); // R2
    AST_RATIO_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_chg && !(&{adc_pwr_dn, dac_pwr_dn})) |=> (status[B_CLK] && status[B_SP])); // R6
    AST_TEST_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode_enter |=> status[B_TM]); // R7
    AST_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_ovfl != '0) |=> ((status[N_ADC-1:0] & $past(adc_ovfl)) == $past(adc_ovfl))); // R8
    AST_STATUS_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status[B_RSV] == 1'b0); // R11
    AST_SP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[B_SP]) |-> $past(ratio_chg || (reg_wr && reg_addr == A_CFG))); // R5
endmodule

// File: tb/cfg_guard_irq_bench.sv
`timescale 1ns/1ps
module cfg_guard_irq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       ratio_chg = 1'b0;
    logic       test_mode_enter = 1'b0;
    logic [3:0] adc_ovfl = '0;
    logic [3:0] adc_pwr_dn;
    logic [3:0] dac_pwr_dn;
    logic [1:0] port_fmt;
    logic [1:0] port_speed;
    logic       irq_n;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] v;
        string      tag;
    } exp_t;
    exp_t exp_q[$];
    logic rd_pend = 1'b0;

    always #2 clk = ~clk;

    cfg_guard_irq u_cfg_guard_irq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ratio_chg(ratio_chg), .test_mode_enter(test_mode_enter),
        .adc_ovfl(adc_ovfl), .adc_pwr_dn(adc_pwr_dn), .dac_pwr_dn(dac_pwr_dn),
        .port_fmt(port_fmt), .port_speed(port_speed), .irq_n(irq_n)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare each read result against the scoreboard queue.
    always @(posedge clk) rd_pend <= reg_rd && rst_n;
    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard empty actual=%h expected=none", reg_rdata);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(reg_rdata, e.v, e.tag);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        exp_t e;
        e.v = exp; e.tag = tag;
        @(negedge clk); reg_rd = 1'b1; reg_addr = a; exp_q.push_back(e);
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic pulse_ratio();
        @(negedge clk); ratio_chg = 1'b1;
        @(negedge clk); ratio_chg = 1'b0;
    endtask

    task automatic pulse_tm();
        @(negedge clk); test_mode_enter = 1'b1;
        @(negedge clk); test_mode_enter = 1'b0;
    endtask

    task automatic pulse_ovfl(input logic [3:0] v);
        @(negedge clk); adc_ovfl = v;
        @(negedge clk); adc_ovfl = '0;
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        @(negedge clk);
        check({7'b0, irq_n}, {7'b0, exp}, tag);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check({adc_pwr_dn, dac_pwr_dn}, 8'hFF, "R1 power bits");
        check({4'b0, port_speed, port_fmt}, 8'h00, "R1 config");
        check({7'b0, irq_n}, 8'h01, "R1 irq_n");
        rd(2'd0, 8'hFF, "R1 power reg");
        rd(2'd2, 8'h00, "R1 mask reg");
        rd(2'd3, 8'h00, "R1 status reg");

        // R2 changes while fully powered down raise nothing
        wr(2'd1, 8'h01);
        check({6'b0, port_fmt}, 8'h01, "R11 fmt field");
        pulse_ratio();
        rd(2'd3, 8'h00, "R2 powered down quiet");

        // R5 same-value write with one ADC powered up
        wr(2'd0, 8'hFE);
        wr(2'd1, 8'h01);
        rd(2'd3, 8'h00, "R5 unchanged write");
        chk_irq(1'b1, "R5 irq idle");

        // R3 format change
        wr(2'd1, 8'h02);
        chk_irq(1'b0, "R3 irq asserted");
        rd(2'd3, 8'h40, "R3 sp error");
        chk_irq(1'b1, "R10 irq after clear");
        rd(2'd3, 8'h00, "R10 cleared");

        // R4 speed change
        wr(2'd1, 8'h06);
        rd(2'd3, 8'h40, "R4 sp error");

        // R6 ratio change with one DAC powered up
        wr(2'd0, 8'h7F);
        pulse_ratio();
        rd(2'd3, 8'h60, "R6 clk and sp error");

        // R7 test mode entry while powered down
        wr(2'd0, 8'hFF);
        pulse_tm();
        rd(2'd3, 8'h80, "R7 test mode error");

        // R8 each overflow channel
        for (int n = 0; n < 4; n++) begin
            pulse_ovfl(4'(1 << n));
            rd(2'd3, 8'(1 << n), "R8 overflow channel");
        end

        // R9 masking
        wr(2'd2, 8'h40);
        wr(2'd0, 8'hEF);
        wr(2'd1, 8'h07);
        chk_irq(1'b1, "R9 masked sp error");
        wr(2'd2, 8'h00);
        chk_irq(1'b0, "R9 unmask exposes sp error");
        rd(2'd3, 8'h40, "R9 status kept under mask");
        wr(2'd2, 8'hFF);
        pulse_ovfl(4'h8);
        chk_irq(1'b1, "R9 masked overflow");
        wr(2'd2, 8'hF7);
        chk_irq(1'b0, "R9 adc4 unmasked");
        rd(2'd2, 8'hE7, "R11 mask reserved bit");
        rd(2'd3, 8'h08, "R8 adc4 overflow");

        // R10 event during the clearing read is kept
        pulse_ovfl(4'h1);
        begin
            exp_t e;
            e.v = 8'h01; e.tag = "R10 read with event";
            @(negedge clk); reg_rd = 1'b1; reg_addr = 2'd3; adc_ovfl = 4'h2;
            exp_q.push_back(e);
            @(negedge clk); reg_rd = 1'b0; adc_ovfl = '0;
        end
        rd(2'd3, 8'h02, "R10 event kept");

        // R11 upper configuration bits read zero
        wr(2'd1, 8'hF6);
        rd(2'd1, 8'h06, "R11 config readback");
        rd(2'd0, 8'hEF, "R11 power readback");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule